// File: doc/BRIEF.md
# Halt and Reset State Sequencer

This block steps a processor through its machine-cycle timing states and handles the halt wait state and reset start-up. In normal running it walks T1, T2 and T3, and adds T4 and T5 when the current machine cycle needs them. A strobe from the instruction logic says that a halt instruction has finished. The sequencer then runs the next machine cycle up to T2 and parks in a halt wait state instead of going to T3.

The halt wait state has only three exits. The first is the processor reset line. The second is a bus hold grant, which moves to a hold state and comes back to the wait state when the grant drops. The third is an interrupt request, which counts only if the interrupt-enable flag was set at the moment the wait state was entered. A reset input only counts as accepted once it has been sampled high on three consecutive clocks. It then produces a single program-counter clear pulse. It never touches the flags or the working registers, because the block has no outputs for them.

Each clock edge stands for one phase-1 rising edge. The current state is presented as a one-hot bus.

Top module: `hrs_sequencer`

## Requirements
- R1: While `reset_in` is sampled high on an edge, the state after that edge is T1, whatever the state before it. `rst` also leaves the state at T1 with `pc_clr` low.
- R2: When no halt is pending, T1 is followed by T2 and T2 by T3. After T3 the sequencer goes to T4 if `cyc_states` is 4 or more, otherwise to T1. After T4 it goes to T5 if `cyc_states` is 5 or more, otherwise to T1. T5 is always followed by T1.
- R3: A `halt_exec` strobe sampled in the final state of a machine cycle makes the next machine cycle run T1, T2, and then enter the halt wait state in place of T3.
- R4: In the halt wait state, with `reset_in` and `hold_grant` low and no qualifying interrupt, the state stays in the halt wait state.
- R5: In the halt wait state, `int_req` high moves the state to T1 on the next edge, provided `int_en` was high on the edge that entered the wait state. Later changes to `int_en` have no effect on this.
- R6: If `int_en` was low on the edge that entered the wait state, `int_req` is ignored, even if `int_en` is set later. Only reset ends the halt.
- R7: In the halt wait state, `hold_grant` high moves the state to the hold state on the next edge. In the hold state, `hold_grant` low returns it to the halt wait state on the next edge.
- R8: When several exit conditions hold on the same edge, `reset_in` wins over `hold_grant`, and `hold_grant` wins over `int_req`.
- R9: `pc_clr` is high for exactly one cycle. It rises after the third consecutive edge on which `reset_in` is sampled high. A reset that is high for fewer than three edges produces no pulse.
- R10: `state_oh` is one-hot with bit 0 = T1, bit 1 = T2, bit 2 = T3, bit 3 = T4, bit 4 = T5, bit 5 = halt wait, bit 6 = hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one phase-1 edge |
| rst | input | 1 | Synchronous active-high block reset |
| reset_in | input | 1 | Processor reset line |
| halt_exec | input | 1 | Halt instruction executed strobe, given in the final state of its cycle |
| int_req | input | 1 | Interrupt request |
| int_en | input | 1 | Interrupt-enable flag |
| hold_grant | input | 1 | Hold granted, from the bus hold sequencer |
| cyc_states | input | 3 | Number of timing states in the current machine cycle (3 to 5) |
| state_oh | output | 7 | One-hot current timing state |
| pc_clr | output | 1 | One-cycle program-counter clear pulse |

## Verification
Every state transition is due exactly one clock edge after the inputs that cause it are applied. `pc_clr` is due one edge after the third consecutive high sample of `reset_in`, so it appears together with the third T1 of a held reset. The driver changes inputs at the falling edge and records the expected value right after the rising edge that should produce it. The monitor compares at the next falling edge, so every comparison falls in the cycle where the result is due, and the halt entry is checked against the T2 of the cycle that follows the strobe.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    typedef enum logic [2:0] {
        ST_T1   = 3'd0,
        ST_T2   = 3'd1,
        ST_T3   = 3'd2,
        ST_T4   = 3'd3,
        ST_T5   = 3'd4,
        ST_WAIT = 3'd5,
        ST_HOLD = 3'd6
    } tstate_e;

    localparam int NUM_STATES = 7;

    typedef struct packed {
        logic halt_pend;
        logic ie_cap;
    } halt_ctx_t;

    function automatic logic is_parked(tstate_e s);
        return (s == ST_WAIT) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/hrs_reset_qual.sv
module hrs_reset_qual #(
    parameter int RST_MIN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic reset_in,
    output logic pc_clr
);
    localparam int CW = $clog2(RST_MIN + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(RST_MIN);
    localparam logic [CW-1:0] CNT_LAST = CW'(RST_MIN - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            pc_clr  <= 1'b0;
        end else begin
            pc_clr <= reset_in && (run_cnt == CNT_LAST);
            if (!reset_in)
                run_cnt <= '0;
            else if (run_cnt != CNT_MAX)
                run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hrs_halt_track.sv
module hrs_halt_track
    import hrs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    reset_in,
    input  logic    halt_exec,
    input  logic    int_en,
    input  tstate_e state,
    output logic    enter_wait,
    output logic    ie_cap
);
    halt_ctx_t ctx;

    assign enter_wait = (state == ST_T2) && ctx.halt_pend && !reset_in;
    assign ie_cap     = ctx.ie_cap;

    always_ff @(posedge clk) begin
        if (rst || reset_in) begin
            ctx <= '0;
        end else begin
            if (enter_wait) begin
                ctx.halt_pend <= 1'b0;
                ctx.ie_cap    <= int_en;
            end else if (halt_exec && !is_parked(state)) begin
                ctx.halt_pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/hrs_state_fsm.sv
module hrs_state_fsm
    import hrs_pkg::*;
#(
    parameter int CYC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reset_in,
    input  logic             enter_wait,
    input  logic             ie_cap,
    input  logic             int_req,
    input  logic             hold_grant,
    input  logic [CYC_W-1:0] cyc_states,
    output tstate_e          state
);
    localparam logic [CYC_W-1:0] NEED_T4 = CYC_W'(4);
    localparam logic [CYC_W-1:0] NEED_T5 = CYC_W'(5);

    tstate_e nxt;

    always_comb begin
        nxt = state;
        if (reset_in) begin
            nxt = ST_T1;
        end else begin
            unique case (state)
                ST_T1:   nxt = ST_T2;
                ST_T2:   nxt = enter_wait ? ST_WAIT : ST_T3;
                ST_T3:   nxt = (cyc_states >= NEED_T4) ? ST_T4 : ST_T1;
                ST_T4:   nxt = (cyc_states >= NEED_T5) ? ST_T5 : ST_T1;
                ST_T5:   nxt = ST_T1;
                ST_WAIT: begin
                    if (hold_grant)
                        nxt = ST_HOLD;
                    else if (int_req && ie_cap)
                        nxt = ST_T1;
                    else
                        nxt = ST_WAIT;
                end
                ST_HOLD: nxt = hold_grant ? ST_HOLD : ST_WAIT;
                default: nxt = ST_T1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_T1;
        else
            state <= nxt;
    end
endmodule

// File: rtl/hrs_sequencer.sv
module hrs_sequencer
    import hrs_pkg::*;
#(
    parameter int RST_MIN = 3,
    parameter int CYC_W   = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reset_in,
    input  logic                  halt_exec,
    input  logic                  int_req,
    input  logic                  int_en,
    input  logic                  hold_grant,
    input  logic [CYC_W-1:0]      cyc_states,
    output logic [NUM_STATES-1:0] state_oh,
    output logic                  pc_clr
);
    tstate_e state;
    logic    enter_wait;
    logic    ie_cap;

    hrs_reset_qual #(.RST_MIN(RST_MIN)) u_rq (
        .clk      (clk),
        .rst      (rst),
        .reset_in (reset_in),
        .pc_clr   (pc_clr)
    );

    hrs_halt_track u_ht (
        .clk        (clk),
        .rst        (rst),
        .reset_in   (reset_in),
        .halt_exec  (halt_exec),
        .int_en     (int_en),
        .state      (state),
        .enter_wait (enter_wait),
        .ie_cap     (ie_cap)
    );

    hrs_state_fsm #(.CYC_W(CYC_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .reset_in   (reset_in),
        .enter_wait (enter_wait),
        .ie_cap     (ie_cap),
        .int_req    (int_req),
        .hold_grant (hold_grant),
        .cyc_states (cyc_states),
        .state      (state)
    );

    for (genvar i = 0; i < NUM_STATES; i++) begin : g_oh
        assign state_oh[i] = (state == tstate_e'(i));
    end
endmodule

// File: rtl/hrs_sequencer_chk.sv
module hrs_sequencer_chk
    import hrs_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  reset_in,
    input logic                  int_req,
    input logic                  hold_grant,
    input logic [NUM_STATES-1:0] state_oh,
    input logic                  pc_clr
);
    localparam int B_T1 = 0, B_T2 = 1, B_WAIT = 5, B_HOLD = 6;

    assert_reset_t1_R1: assert property (@(posedge clk) disable iff (rst)
        reset_in |=> state_oh[B_T1]);

    assert_t1_to_t2_R2: assert property (@(posedge clk) disable iff (rst)
        (state_oh[B_T1] && !reset_in) |=> state_oh[B_T2]);

    assert_wait_stays_R4: assert property (@(posedge clk) disable iff (rst)
        (state_oh[B_WAIT] && !reset_in && !hold_grant && !int_req) |=> state_oh[B_WAIT]);

    assert_hold_enter_R7: assert property (@(posedge clk) disable iff (rst)
        (state_oh[B_WAIT] && !reset_in && hold_grant) |=> state_oh[B_HOLD]);

    assert_hold_leave_R7: assert property (@(posedge clk) disable iff (rst)
        (state_oh[B_HOLD] && !reset_in && !hold_grant) |=> state_oh[B_WAIT]);

    assert_hold_over_int_R8: assert property (@(posedge clk) disable iff (rst)
        (state_oh[B_WAIT] && !reset_in && hold_grant && int_req) |=> state_oh[B_HOLD]);

    assert_pc_clr_single_R9: assert property (@(posedge clk) disable iff (rst)
        pc_clr |=> !pc_clr);

    assert_pc_clr_qual_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(pc_clr) |-> ($past(reset_in) && state_oh[B_T1]));

    assert_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1);
endmodule

bind hrs_sequencer hrs_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reset_in   (reset_in),
    .int_req    (int_req),
    .hold_grant (hold_grant),
    .state_oh   (state_oh),
    .pc_clr     (pc_clr)
);

// File: tb/test_hrs_sequencer.sv
module test_hrs_sequencer;
    localparam logic [6:0] S_T1 = 7'b0000001;
    localparam logic [6:0] S_T2 = 7'b0000010;
    localparam logic [6:0] S_T3 = 7'b0000100;
    localparam logic [6:0] S_T4 = 7'b0001000;
    localparam logic [6:0] S_T5 = 7'b0010000;
    localparam logic [6:0] S_WT = 7'b0100000;
    localparam logic [6:0] S_HD = 7'b1000000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reset_in = 1'b0, halt_exec = 1'b0, int_req = 1'b0, int_en = 1'b0, hold_grant = 1'b0;
    logic [2:0] cyc_states = 3'd3;
    logic [6:0] state_oh;
    logic pc_clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] st;
        logic       pc;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    hrs_sequencer i_hrs_sequencer (
        .clk(clk), .rst(rst), .reset_in(reset_in), .halt_exec(halt_exec),
        .int_req(int_req), .int_en(int_en), .hold_grant(hold_grant),
        .cyc_states(cyc_states), .state_oh(state_oh), .pc_clr(pc_clr)
    );

    // Driver: apply inputs, record the value due after the next rising edge.
    task automatic step(input logic r, input logic hx, input logic ir, input logic ie,
                        input logic hg, input logic [2:0] cs,
                        input logic [6:0] est, input logic epc, input string tag);
        reset_in = r; halt_exec = hx; int_req = ir; int_en = ie; hold_grant = hg; cyc_states = cs;
        @(posedge clk);
        sb.push_back('{est, epc, tag});
        @(negedge clk);
    endtask

    task automatic idle(input logic [6:0] est, input string tag);
        step(0, 0, 0, int_en, 0, 3'd3, est, 1'b0, tag);
    endtask

    // Monitor: compare in the cycle the result is due.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (state_oh !== e.st || pc_clr !== e.pc) begin
                errors++;
                $display("FAIL %s: state_oh=%b pc_clr=%b expected state_oh=%b pc_clr=%b",
                         e.tag, state_oh, pc_clr, e.st, e.pc);
            end
        end
    end

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checks++;
        if (state_oh !== S_T1 || pc_clr !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: state_oh=%b pc_clr=%b expected %b 0", state_oh, pc_clr, S_T1);
        end

        // R2: three-, four- and five-state machine cycles
        step(0,0,0,0,0,3'd3, S_T2, 0, "R2 T1->T2");
        step(0,0,0,0,0,3'd3, S_T3, 0, "R2 T2->T3");
        step(0,0,0,0,0,3'd3, S_T1, 0, "R2 3-state end");
        step(0,0,0,0,0,3'd4, S_T2, 0, "R2 T2");
        step(0,0,0,0,0,3'd4, S_T3, 0, "R2 T3");
        step(0,0,0,0,0,3'd4, S_T4, 0, "R2 T3->T4");
        step(0,0,0,0,0,3'd4, S_T1, 0, "R2 4-state end");
        step(0,0,0,0,0,3'd5, S_T2, 0, "R2 T2");
        step(0,0,0,0,0,3'd5, S_T3, 0, "R2 T3");
        step(0,0,0,0,0,3'd5, S_T4, 0, "R2 T4");
        step(0,0,0,0,0,3'd5, S_T5, 0, "R2 T4->T5");
        step(0,0,0,0,0,3'd5, S_T1, 0, "R2 5-state end");

        // R3: halt with interrupts enabled at entry
        step(0,0,0,1,0,3'd3, S_T2, 0, "R3 pre");
        step(0,0,0,1,0,3'd3, S_T3, 0, "R3 pre");
        step(0,1,0,1,0,3'd3, S_T1, 0, "R3 strobe in final state");
        step(0,0,0,1,0,3'd3, S_T2, 0, "R3 next cycle T2");
        step(0,0,0,1,0,3'd3, S_WT, 0, "R3 enter halt wait");
        step(0,0,0,0,0,3'd3, S_WT, 0, "R4 stays halted");
        step(0,0,0,0,0,3'd3, S_WT, 0, "R4 stays halted");
        // R8: hold beats interrupt; R7 hold and return
        step(0,0,1,0,1,3'd3, S_HD, 0, "R8 hold over int");
        step(0,0,1,0,1,3'd3, S_HD, 0, "R7 stays in hold");
        step(0,0,0,0,0,3'd3, S_WT, 0, "R7 back to halt wait");
        // R5: captured enable qualifies exit though int_en now low
        step(0,0,1,0,0,3'd3, S_T1, 0, "R5 interrupt exit");
        step(0,0,0,0,0,3'd3, S_T2, 0, "R5 resumes");
        step(0,0,0,0,0,3'd3, S_T3, 0, "R5 resumes");

        // R6: halt entered with interrupts disabled
        step(0,1,0,0,0,3'd3, S_T1, 0, "R6 strobe");
        step(0,0,0,0,0,3'd3, S_T2, 0, "R6 T2");
        step(0,0,0,0,0,3'd3, S_WT, 0, "R6 enter halt wait");
        step(0,0,1,1,0,3'd3, S_WT, 0, "R6 interrupt ignored");
        step(0,0,1,1,0,3'd3, S_WT, 0, "R6 interrupt ignored");
        step(0,0,0,1,1,3'd3, S_HD, 0, "R7 hold from halt");
        step(0,0,0,1,0,3'd3, S_WT, 0, "R7 return to halt");
        // R8: reset beats hold; R9 short reset gives no pulse
        step(1,0,1,1,1,3'd3, S_T1, 0, "R8 reset over hold");
        step(1,0,0,0,0,3'd3, S_T1, 0, "R9 short reset no pulse");
        step(0,0,0,0,0,3'd3, S_T2, 0, "R9 after short reset");
        step(0,0,0,0,0,3'd3, S_T3, 0, "R9 after short reset");
        // R9: qualified reset
        step(1,0,0,0,0,3'd3, S_T1, 0, "R9 reset edge 1");
        step(1,0,0,0,0,3'd3, S_T1, 0, "R9 reset edge 2");
        step(1,0,0,0,0,3'd3, S_T1, 1, "R9 pc clear on edge 3");
        step(1,0,0,0,0,3'd3, S_T1, 0, "R9 single pulse");
        step(0,0,0,0,0,3'd3, S_T2, 0, "R1 run after reset");
        idle(S_T3, "R2 after reset");
        @(negedge clk);

        done = 1'b1;
        summary();
    end
endmodule